// File: doc/BRIEF.md
# Dual-Channel UART Interrupt Merger

This block gathers the interrupt conditions of two serial channels, plus two sources that belong to the whole device, into one 32-bit global status word and one interrupt request line. The inputs are raw levels and one-cycle events coming from each channel's datapath: receive FIFO at or above its trigger, receive timeout, the four receive error/break flags, transmit ready, a modem or flow-control change, Xon/Xoff detection, special-character detection, a GPIO pin interrupt and a timer expiry. The events are latched into sticky pending flags. Each flag is released by its own clear condition: a strobe that stands for a read of a particular register, a FIFO level indication, or the arrival of the next character.

For each channel, the word carries a summary bit and a packed 3-bit code. The code names the single pending source with the highest priority, so interrupt service software can branch to that source from one read. The two device-wide sources can appear only in channel 0's code.

Top module: `uart_irq_merge`

## Requirements
- R1: Word layout. Bit c (c = 0, 1) is channel c's summary bit. Bits 8+3c+2 .. 8+3c hold channel c's 3-bit code (channel 0 uses bits 10:8, channel 1 uses bits 13:11). Every other bit reads 0.
- R2: Code values. 000 means nothing pending. 001 means receive data ready or receive line status. 010 means receive timeout. 011 means transmit ready. 100 means modem/flow-control change, Xon/Xoff detected or special character. 110 means GPIO pin interrupt. 111 means timer expiry. 101 is never produced. A change on an input shows in `gstat` after the second rising clock edge that samples it.
- R3: When several enabled sources are pending, the code is the smallest non-zero value among them.
- R4: Codes 110 and 111 appear only in channel 0. Channel 1's code never exceeds 100.
- R5: The receive-ready condition follows `rx_above_trig`. It goes away only when that level drops.
- R6: A receive-timeout event stays pending until `rx_fifo_empty` is high. Register-read strobes do not affect it.
- R7: A rising edge of the OR of a channel's four `lsr_err` flags sets line status, and `lsr_rd` clears it. A modem/flow-control change is cleared by `msr_rd`.
- R8: Transmit ready and Xon/Xoff are cleared by `isr_rd`. `msr_rd` has no effect on either of them.
- R9: A special character is cleared by `isr_rd` or by `rx_char_evt`, whichever comes first.
- R10: The timer source is cleared by `timer_rd`, and the GPIO source is cleared by `gpio_rd`.
- R11: If a set and a clear of the same sticky flag happen in the same cycle, the flag stays set.
- R12: Enable bits of `src_en`, per channel c at bits 4c..4c+3: bit 0 gates receive ready and line status, bit 1 gates timeout, bit 2 gates transmit, bit 3 gates the modem group. `dev_en` bit 0 gates GPIO and bit 1 gates the timer. A disabled source is hidden but stays pending. A summary bit is the OR of its channel's enabled pending sources, and `irq` is the OR of the summary bits.
- R13: While `rst_n` is low at a rising edge, every pending flag clears and `gstat` and `irq` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_above_trig | input | 2 | Receive FIFO at/above trigger, per channel |
| rx_fifo_empty | input | 2 | Receive FIFO empty, per channel |
| rx_tmo_evt | input | 2 | Receive timeout event |
| rx_char_evt | input | 2 | A character was received |
| lsr_err | input | 8 | Four error/break flags per channel |
| tx_rdy_evt | input | 2 | Transmit ready/empty event |
| modem_evt | input | 2 | Modem or flow-control change |
| xoff_evt | input | 2 | Xon/Xoff detected |
| spchar_evt | input | 2 | Special character detected |
| lsr_rd | input | 2 | Line-status read strobe |
| msr_rd | input | 2 | Modem-status read strobe |
| isr_rd | input | 2 | Interrupt-status read strobe |
| src_en | input | 8 | Per-channel source group enables |
| gpio_evt | input | 1 | GPIO pin interrupt event |
| gpio_rd | input | 1 | GPIO level read strobe |
| timer_evt | input | 1 | Timer expiry event |
| timer_rd | input | 1 | Timer control read strobe |
| dev_en | input | 2 | Device source enables |
| gstat | output | 32 | Global interrupt status word |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties assume the following about the inputs:
- Events and read strobes are synchronous to `clk`.
- Sticky flags respond to the rising edge of an event, so an event input must fall before a second occurrence of the same source can set it again.

The stimulus meets these assumptions. It changes inputs only on the falling clock edge, and it holds every event and strobe high for exactly one cycle before returning it to zero. The receive-ready level is the one exception: it is left high until a test deliberately lowers it.

// File: rtl/uart_irq_merge.sv
module uart_irq_merge #(
  parameter int N_CH = 2,
  parameter int LS_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_CH-1:0]        rx_above_trig,
  input  logic [N_CH-1:0]        rx_fifo_empty,
  input  logic [N_CH-1:0]        rx_tmo_evt,
  input  logic [N_CH-1:0]        rx_char_evt,
  input  logic [LS_W*N_CH-1:0]   lsr_err,
  input  logic [N_CH-1:0]        tx_rdy_evt,
  input  logic [N_CH-1:0]        modem_evt,
  input  logic [N_CH-1:0]        xoff_evt,
  input  logic [N_CH-1:0]        spchar_evt,
  input  logic [N_CH-1:0]        lsr_rd,
  input  logic [N_CH-1:0]        msr_rd,
  input  logic [N_CH-1:0]        isr_rd,
  input  logic [4*N_CH-1:0]      src_en,
  input  logic                   gpio_evt,
  input  logic                   gpio_rd,
  input  logic                   timer_evt,
  input  logic                   timer_rd,
  input  logic [1:0]             dev_en,
  output logic [31:0]            gstat,
  output logic                   irq
);
  localparam int CW = 3;
  localparam int CODE_LSB = 8;
  localparam logic [31:0] USED =
    ((32'h1 << N_CH) - 32'h1) | (((32'h1 << (CW*N_CH)) - 32'h1) << CODE_LSB);

  logic gp_p, gp_h, tm_p, tm_h;
  logic gp_set, tm_set;
  logic [CW*N_CH-1:0] code_all;
  logic [N_CH-1:0]    any_all;
  logic [31:0]        gstat_n;

  assign gp_set = gpio_evt & ~gp_h;
  assign tm_set = timer_evt & ~tm_h;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gp_p <= 1'b0; gp_h <= 1'b0;
      tm_p <= 1'b0; tm_h <= 1'b0;
    end else begin
      gp_h <= gpio_evt;
      tm_h <= timer_evt;
      gp_p <= gp_set | (gp_p & ~gpio_rd);
      tm_p <= tm_set | (tm_p & ~timer_rd);
    end
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic rdy_q, ls_p, tmo_p, tx_p, mdm_p, xo_p, sc_p;
    logic ls_h, tmo_h, tx_h, mdm_h, xo_h, sc_h;
    logic ls_now, ls_set;
    logic p1, p2, p3, p4, gp_v, tm_v;
    logic [3:0] en;

    assign ls_now = |lsr_err[LS_W*c +: LS_W];
    assign ls_set = ls_now & ~ls_h;
    assign en     = src_en[4*c +: 4];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rdy_q <= 1'b0;
        {ls_p, tmo_p, tx_p, mdm_p, xo_p, sc_p} <= '0;
        {ls_h, tmo_h, tx_h, mdm_h, xo_h, sc_h} <= '0;
      end else begin
        rdy_q <= rx_above_trig[c];
        ls_h  <= ls_now;
        tmo_h <= rx_tmo_evt[c];
        tx_h  <= tx_rdy_evt[c];
        mdm_h <= modem_evt[c];
        xo_h  <= xoff_evt[c];
        sc_h  <= spchar_evt[c];
        ls_p  <= ls_set | (ls_p & ~lsr_rd[c]);
        tmo_p <= (rx_tmo_evt[c] & ~tmo_h) | (tmo_p & ~rx_fifo_empty[c]);
        tx_p  <= (tx_rdy_evt[c] & ~tx_h)  | (tx_p  & ~isr_rd[c]);
        mdm_p <= (modem_evt[c] & ~mdm_h)  | (mdm_p & ~msr_rd[c]);
        xo_p  <= (xoff_evt[c] & ~xo_h)    | (xo_p  & ~isr_rd[c]);
        sc_p  <= (spchar_evt[c] & ~sc_h)  | (sc_p & ~(isr_rd[c] | rx_char_evt[c]));
      end
    end

    assign p1   = en[0] & (rdy_q | ls_p);
    assign p2   = en[1] & tmo_p;
    assign p3   = en[2] & tx_p;
    assign p4   = en[3] & (mdm_p | xo_p | sc_p);
    assign gp_v = (c == 0) ? (gp_p & dev_en[0]) : 1'b0;
    assign tm_v = (c == 0) ? (tm_p & dev_en[1]) : 1'b0;

    assign code_all[CW*c +: CW] = p1 ? 3'd1 : p2 ? 3'd2 : p3 ? 3'd3 :
                                  p4 ? 3'd4 : gp_v ? 3'd6 : tm_v ? 3'd7 : 3'd0;
    assign any_all[c] = p1 | p2 | p3 | p4 | gp_v | tm_v;

    // R1
    sum_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gstat[c] == (gstat[CODE_LSB+CW*c +: CW] != 3'd0));
    // R2
    no_rsvd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gstat[CODE_LSB+CW*c +: CW] != 3'd5);
    if (c > 0) begin : g_hi
      // R4
      no_dev_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gstat[CODE_LSB+CW*c +: CW] <= 3'd4);
    end
    // R11
    ls_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ls_set && lsr_rd[c] |=> ls_p);
    // R7
    ls_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lsr_rd[c] && !ls_set |=> !ls_p);
    // R9
    sc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_char_evt[c] && !(spchar_evt[c] && !sc_h) |=> !sc_p);
  end

  always_comb begin
    gstat_n = '0;
    for (int c = 0; c < N_CH; c++) begin
      gstat_n[c] = any_all[c];
      gstat_n[CODE_LSB + CW*c +: CW] = code_all[CW*c +: CW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gstat <= '0;
      irq   <= 1'b0;
    end else begin
      gstat <= gstat_n;
      irq   <= |any_all;
    end
  end

  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gstat & ~USED) == 32'h0);
  // R12
  irq_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |gstat[N_CH-1:0]);
  // R11
  tm_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tm_set && timer_rd |=> tm_p);
  // R10
  tm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timer_rd && !tm_set |=> !tm_p);
  // R10
  gp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gpio_rd && !gp_set |=> !gp_p);
  // R13
  reset_out_chk: assert property (@(posedge clk)
    !rst_n |=> gstat == 32'h0 && !irq);
endmodule

// File: tb/uart_irq_merge_tb.sv
`timescale 1ns/1ps
module uart_irq_merge_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] rx_above_trig = '0, rx_fifo_empty = '0, rx_tmo_evt = '0, rx_char_evt = '0;
  logic [7:0] lsr_err = '0;
  logic [1:0] tx_rdy_evt = '0, modem_evt = '0, xoff_evt = '0, spchar_evt = '0;
  logic [1:0] lsr_rd = '0, msr_rd = '0, isr_rd = '0;
  logic [7:0] src_en = 8'hFF;
  logic gpio_evt = 1'b0, gpio_rd = 1'b0, timer_evt = 1'b0, timer_rd = 1'b0;
  logic [1:0] dev_en = 2'b11;
  logic [31:0] gstat;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_irq_merge dut_i (
    .clk(clk), .rst_n(rst_n), .rx_above_trig(rx_above_trig), .rx_fifo_empty(rx_fifo_empty),
    .rx_tmo_evt(rx_tmo_evt), .rx_char_evt(rx_char_evt), .lsr_err(lsr_err),
    .tx_rdy_evt(tx_rdy_evt), .modem_evt(modem_evt), .xoff_evt(xoff_evt),
    .spchar_evt(spchar_evt), .lsr_rd(lsr_rd), .msr_rd(msr_rd), .isr_rd(isr_rd),
    .src_en(src_en), .gpio_evt(gpio_evt), .gpio_rd(gpio_rd), .timer_evt(timer_evt),
    .timer_rd(timer_rd), .dev_en(dev_en), .gstat(gstat), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drop all events, strobes and error flags, then wait for the result.
  task automatic step();
    @(negedge clk);
    rx_tmo_evt = '0; rx_char_evt = '0; lsr_err = '0; tx_rdy_evt = '0;
    modem_evt = '0; xoff_evt = '0; spchar_evt = '0; lsr_rd = '0; msr_rd = '0;
    isr_rd = '0; gpio_evt = 0; gpio_rd = 0; timer_evt = 0; timer_rd = 0;
    rx_fifo_empty = '0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 0; rx_above_trig = '0; src_en = 8'hFF; dev_en = 2'b11;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
  endtask

  // mask bits: 0 rx ready, 1 line status, 2 timeout, 3 tx, 4 modem, 5 xoff, 6 special, 7 gpio, 8 timer
  task automatic drive(input int c, input logic [8:0] m, input int lsb);
    rx_above_trig[c] = m[0];
    lsr_err[4*c + lsb] = m[1];
    rx_tmo_evt[c] = m[2]; tx_rdy_evt[c] = m[3]; modem_evt[c] = m[4];
    xoff_evt[c] = m[5]; spchar_evt[c] = m[6];
    if (c == 0) begin gpio_evt = m[7]; timer_evt = m[8]; end
  endtask

  function automatic logic [2:0] exp_code(input logic [8:0] m);
    if (m[0] | m[1]) return 3'd1;
    if (m[2]) return 3'd2;
    if (m[3]) return 3'd3;
    if (|m[6:4]) return 3'd4;
    if (m[7]) return 3'd6;
    if (m[8]) return 3'd7;
    return 3'd0;
  endfunction

  function automatic logic [31:0] exp_word(input logic [2:0] c0, input logic [2:0] c1);
    return {18'h0, c1, c0, 6'h0, c1 != 3'd0, c0 != 3'd0};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R13: reset holds outputs low even with inputs active
    rx_above_trig = 2'b11; gpio_evt = 1;
    @(negedge clk); @(negedge clk);
    chk("R13 word in reset", gstat, 32'h0);
    chk("R13 irq in reset", {31'h0, irq}, 32'h0);
    gpio_evt = 0;

    // R1 R2 R3 R4 R12: sweep of source combinations on both channels
    for (int i = 0; i < 512; i++) begin
      automatic logic [8:0] m0 = 9'(i);
      automatic logic [8:0] m1 = {2'b00, 7'(i * 37 + 11)};
      do_reset();
      @(negedge clk);
      drive(0, m0, i % 4);
      drive(1, m1, (i / 4) % 4);
      step();
      chk("R1 R2 R3 R4 word", gstat, exp_word(exp_code(m0), exp_code(m1)));
      chk("R12 irq", {31'h0, irq}, {31'h0, (m0 != 0) || (m1 != 0)});
    end

    // Clear conditions with every channel 0 source pending
    do_reset(); @(negedge clk);
    drive(0, 9'h1FF, 2); step();
    chk("R3 all pending", gstat, exp_word(3'd1, 3'd0));
    rx_above_trig[0] = 0; step();
    chk("R5 rx level gone, line status holds", gstat, exp_word(3'd1, 3'd0));
    lsr_rd[0] = 1; step();
    chk("R7 line status cleared", gstat, exp_word(3'd2, 3'd0));
    rx_fifo_empty[0] = 1; step();
    chk("R6 timeout cleared by empty", gstat, exp_word(3'd3, 3'd0));
    msr_rd[0] = 1; step();
    chk("R8 msr read leaves tx", gstat, exp_word(3'd3, 3'd0));
    isr_rd[0] = 1; step();
    chk("R8 R9 isr read clears tx xoff special", gstat, exp_word(3'd6, 3'd0));
    gpio_rd = 1; step();
    chk("R10 gpio cleared", gstat, exp_word(3'd7, 3'd0));
    timer_rd = 1; step();
    chk("R10 timer cleared", gstat, 32'h0);
    chk("R12 irq low when empty", {31'h0, irq}, 32'h0);

    // R5: receive-ready follows its level
    do_reset(); @(negedge clk);
    rx_above_trig[1] = 1; step();
    chk("R5 rx ready shown", gstat, exp_word(3'd0, 3'd1));
    rx_above_trig[1] = 0; step();
    chk("R5 rx ready gone", gstat, 32'h0);

    // R8: xoff ignores modem-status read
    do_reset(); @(negedge clk);
    drive(1, 9'h020, 0); step();
    msr_rd[1] = 1; step();
    chk("R8 xoff kept after msr read", gstat, exp_word(3'd0, 3'd4));
    isr_rd[1] = 1; step();
    chk("R8 xoff cleared by isr read", gstat, 32'h0);

    // R9: special character cleared by next character
    do_reset(); @(negedge clk);
    drive(0, 9'h040, 0); step();
    chk("R9 special pending", gstat, exp_word(3'd4, 3'd0));
    rx_char_evt[0] = 1; step();
    chk("R9 special cleared by next char", gstat, 32'h0);

    // R6: timeout ignores read strobes
    do_reset(); @(negedge clk);
    drive(1, 9'h004, 0); step();
    isr_rd[1] = 1; lsr_rd[1] = 1; msr_rd[1] = 1; step();
    chk("R6 timeout kept after reads", gstat, exp_word(3'd0, 3'd2));
    rx_fifo_empty[1] = 1; step();
    chk("R6 timeout cleared", gstat, 32'h0);

    // R11: set and clear in the same cycle
    do_reset(); @(negedge clk);
    timer_evt = 1; timer_rd = 1;
    lsr_err[5] = 1; lsr_rd[1] = 1;
    step();
    chk("R11 same-cycle set wins", gstat, exp_word(3'd7, 3'd1));

    // R12: enables hide but keep pending sources
    do_reset(); @(negedge clk);
    src_en[0] = 0;
    drive(0, 9'h1FF, 1); step();
    chk("R12 rx group disabled", gstat, exp_word(3'd2, 3'd0));
    src_en = 8'h00; dev_en = 2'b00; @(negedge clk); @(negedge clk);
    chk("R12 all disabled word", gstat, 32'h0);
    chk("R12 all disabled irq", {31'h0, irq}, 32'h0);
    dev_en = 2'b10; @(negedge clk); @(negedge clk);
    chk("R12 timer enabled alone", gstat, exp_word(3'd7, 3'd0));
    src_en = 8'hFF; dev_en = 2'b11; @(negedge clk); @(negedge clk);
    chk("R12 re-enabled", gstat, exp_word(3'd1, 3'd0));
    chk("R12 irq re-enabled", {31'h0, irq}, 32'h1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule